// File: doc/BRIEF.md
# USB Host Endpoint-0 Control and Status Register

This block holds the 16-bit control and status word for endpoint 0 of a USB controller acting as host. The CPU reads and writes the word over a simple register port: the write takes effect on the next clock edge and the read is combinational. The transaction engine sends in single-cycle event strobes:

- packet sent
- packet received
- STALL handshake seen
- no response after repeated attempts
- NAK limit reached
- data toggle advance

These strobes set or clear the matching bits. The block drives three kinds of output: the live control bits to the engine, a one-cycle pulse that resets the endpoint-0 FIFO pointer, and one-cycle interrupt request pulses.

Several bits are linked. The data toggle can be overwritten only through a companion enable bit. That enable is never stored, and it always reads as zero. A flush request acts only while a packet-ready bit is set. A packet reception clears the pending IN request. When the CPU and the hardware touch the same bit in one cycle, the hardware event wins.

Top module: `ep0_host_ctrl_reg`

## Requirements
- R1: After reset every register bit is 0 and all pulse outputs are low. Bits 15:12, bit 10 (toggle-load enable) and bit 8 (flush) always read 0.
- R2: Bit 9 reads the current data toggle. A CPU write changes the toggle to the written bit 9 only when bit 10 of the same write is 1; otherwise the written bit 9 is ignored.
- R3: A write with bit 6 (status stage) set and with bit 1 (TX ready) or bit 5 (IN request) set forces the toggle to 1.
- R4: The toggle-advance event inverts the toggle, unless a CPU write loads or forces the toggle in the same cycle; in that case the CPU value is used.
- R5: A write with bit 8 set while bit 0 or bit 1 is set clears both bits and pulses fifoPtrReset for one cycle after the write edge. It also overrides a bit-1 value written in the same cycle.
- R6: A write with bit 8 set while bits 0 and 1 are both clear does not pulse fifoPtrReset. The rest of that write applies normally.
- R7: The packet-sent event clears bit 1. irqTx pulses one cycle later only if bit 1 was set and irqTxEn is high.
- R8: The packet-received event sets bit 0, clears bit 5 and pulses irqRx. CPU writes never change bit 0. The svcRxReady strobe clears bit 0.
- R9: The STALL, no-response and NAK-limit events set bits 2, 4 and 7 respectively. The no-response event also pulses irqErr. A CPU write of 0 clears these bits.
- R10: When a hardware event and a CPU write or service strobe act on the same bit in the same cycle, the hardware event's value is taken.
- R11: Bits 11, 6, 5, 3 and 1 are CPU read/write. The ctrl* outputs mirror bits 11, 9, 6, 5, 3 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | CPU write strobe |
| wrData | input | 16 | CPU write data |
| rdData | output | 16 | Register read value |
| svcRxReady | input | 1 | Service strobe that clears RX ready |
| irqTxEn | input | 1 | Enables the TX-done interrupt |
| evTxDone | input | 1 | Packet sent |
| evRxPkt | input | 1 | Packet received |
| evStall | input | 1 | STALL handshake received |
| evNoResp | input | 1 | No response after retries |
| evNakLimit | input | 1 | NAK limit reached |
| evToggleAdv | input | 1 | Data toggle advance |
| ctrlPingOff | output | 1 | Suppress PING tokens |
| ctrlToggle | output | 1 | Current data toggle |
| ctrlStatusStage | output | 1 | Status-stage transaction |
| ctrlInReq | output | 1 | IN transaction requested |
| ctrlSetup | output | 1 | Send SETUP instead of OUT |
| ctrlTxReady | output | 1 | TX packet loaded |
| fifoPtrReset | output | 1 | FIFO pointer reset pulse |
| irqTx | output | 1 | TX-done interrupt pulse |
| irqRx | output | 1 | RX interrupt pulse |
| irqErr | output | 1 | No-response interrupt pulse |

## Verification
The hardest situations to reach are same-cycle collisions. These include:
- a flush write that also writes bit 1 while both ready bits are clear;
- a toggle-load write arriving together with a toggle-advance event;
- a reception arriving together with the service strobe or with a CPU write.

The stimulus table reaches each of these by first building up a known register state over several rows. The next row then drives the write and the event in the same cycle. The table checks the read value, the flush pulse and the interrupt pulses right after that edge.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
  localparam int REG_W    = 16;
  localparam int B_PING   = 11;
  localparam int B_TOGEN  = 10;
  localparam int B_TOG    = 9;
  localparam int B_FLUSH  = 8;
  localparam int B_NAK    = 7;
  localparam int B_STAGE  = 6;
  localparam int B_INREQ  = 5;
  localparam int B_ERR    = 4;
  localparam int B_SETUP  = 3;
  localparam int B_STALL  = 2;
  localparam int B_TXRDY  = 1;
  localparam int B_RXRDY  = 0;

  typedef struct packed {
    logic cpuWr;
    logic togLoad;
    logic togForce;
    logic togFlip;
    logic flushHit;
    logic txClr;
    logic txIrq;
    logic rxSet;
    logic rxClr;
    logic inReqClr;
    logic stallSet;
    logic errSet;
    logic nakSet;
  } ep0Strobes_t;

  typedef struct packed {
    logic pingOff;
    logic toggle;
    logic nakHit;
    logic stage;
    logic inReq;
    logic err;
    logic setup;
    logic stall;
    logic txRdy;
    logic rxRdy;
  } ep0State_t;
endpackage

// File: rtl/ep0_csr_ctrl.sv
module ep0_csr_ctrl
  import ep0_csr_pkg::*;
(
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             svcRxReady,
  input  logic             irqTxEn,
  input  logic             evTxDone,
  input  logic             evRxPkt,
  input  logic             evStall,
  input  logic             evNoResp,
  input  logic             evNakLimit,
  input  logic             evToggleAdv,
  input  logic             txRdyQ,
  input  logic             rxRdyQ,
  output ep0Strobes_t      stb
);
  logic loadReq;
  logic forceReq;

  always_comb begin
    loadReq  = wrEn & wrData[B_TOGEN];
    forceReq = wrEn & wrData[B_STAGE] & (wrData[B_TXRDY] | wrData[B_INREQ]);
    stb.cpuWr    = wrEn;
    stb.togLoad  = loadReq;
    stb.togForce = forceReq;
    stb.togFlip  = evToggleAdv & ~loadReq & ~forceReq;
    stb.flushHit = wrEn & wrData[B_FLUSH] & (txRdyQ | rxRdyQ);
    stb.txClr    = evTxDone;
    stb.txIrq    = evTxDone & txRdyQ & irqTxEn;
    stb.rxSet    = evRxPkt;
    stb.rxClr    = svcRxReady;
    stb.inReqClr = evRxPkt;
    stb.stallSet = evStall;
    stb.errSet   = evNoResp;
    stb.nakSet   = evNakLimit;
  end
endmodule

// File: rtl/ep0_csr_dp.sv
module ep0_csr_dp
  import ep0_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] wrData,
  input  ep0Strobes_t      stb,
  output ep0State_t        st,
  output logic             ptrResetQ,
  output logic             irqTxQ,
  output logic             irqRxQ,
  output logic             irqErrQ
);
  ep0State_t nxt;

  always_comb begin
    nxt = st;
    if (stb.cpuWr) begin
      nxt.pingOff = wrData[B_PING];
      nxt.stage   = wrData[B_STAGE];
      nxt.setup   = wrData[B_SETUP];
      nxt.inReq   = wrData[B_INREQ];
      nxt.txRdy   = wrData[B_TXRDY];
      nxt.stall   = wrData[B_STALL];
      nxt.err     = wrData[B_ERR];
      nxt.nakHit  = wrData[B_NAK];
    end
    if (stb.togForce)      nxt.toggle = 1'b1;
    else if (stb.togLoad)  nxt.toggle = wrData[B_TOG];
    else if (stb.togFlip)  nxt.toggle = ~st.toggle;
    if (stb.inReqClr)      nxt.inReq  = 1'b0;
    if (stb.stallSet)      nxt.stall  = 1'b1;
    if (stb.errSet)        nxt.err    = 1'b1;
    if (stb.nakSet)        nxt.nakHit = 1'b1;
    if (stb.flushHit | stb.txClr) nxt.txRdy = 1'b0;
    if (stb.rxSet)         nxt.rxRdy  = 1'b1;
    else if (stb.rxClr | stb.flushHit) nxt.rxRdy = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= '0;
      ptrResetQ <= 1'b0;
      irqTxQ    <= 1'b0;
      irqRxQ    <= 1'b0;
      irqErrQ   <= 1'b0;
    end else begin
      st        <= nxt;
      ptrResetQ <= stb.flushHit;
      irqTxQ    <= stb.txIrq;
      irqRxQ    <= stb.rxSet;
      irqErrQ   <= stb.errSet;
    end
  end
endmodule

// File: rtl/ep0_host_ctrl_reg.sv
module ep0_host_ctrl_reg
  import ep0_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        svcRxReady,
  input  logic        irqTxEn,
  input  logic        evTxDone,
  input  logic        evRxPkt,
  input  logic        evStall,
  input  logic        evNoResp,
  input  logic        evNakLimit,
  input  logic        evToggleAdv,
  output logic        ctrlPingOff,
  output logic        ctrlToggle,
  output logic        ctrlStatusStage,
  output logic        ctrlInReq,
  output logic        ctrlSetup,
  output logic        ctrlTxReady,
  output logic        fifoPtrReset,
  output logic        irqTx,
  output logic        irqRx,
  output logic        irqErr
);
  ep0Strobes_t stb;
  ep0State_t   st;

  ep0_csr_ctrl u_ctrl (
    .wrEn(wrEn), .wrData(wrData), .svcRxReady(svcRxReady), .irqTxEn(irqTxEn),
    .evTxDone(evTxDone), .evRxPkt(evRxPkt), .evStall(evStall),
    .evNoResp(evNoResp), .evNakLimit(evNakLimit), .evToggleAdv(evToggleAdv),
    .txRdyQ(st.txRdy), .rxRdyQ(st.rxRdy), .stb(stb)
  );

  ep0_csr_dp u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .stb(stb), .st(st),
    .ptrResetQ(fifoPtrReset), .irqTxQ(irqTx), .irqRxQ(irqRx), .irqErrQ(irqErr)
  );

  always_comb begin
    rdData          = '0;
    rdData[B_PING]  = st.pingOff;
    rdData[B_TOG]   = st.toggle;
    rdData[B_NAK]   = st.nakHit;
    rdData[B_STAGE] = st.stage;
    rdData[B_INREQ] = st.inReq;
    rdData[B_ERR]   = st.err;
    rdData[B_SETUP] = st.setup;
    rdData[B_STALL] = st.stall;
    rdData[B_TXRDY] = st.txRdy;
    rdData[B_RXRDY] = st.rxRdy;
  end

  assign ctrlPingOff     = st.pingOff;
  assign ctrlToggle      = st.toggle;
  assign ctrlStatusStage = st.stage;
  assign ctrlInReq       = st.inReq;
  assign ctrlSetup       = st.setup;
  assign ctrlTxReady     = st.txRdy;
endmodule

// File: rtl/ep0_csr_chk.sv
module ep0_csr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic        evTxDone,
  input logic        evRxPkt,
  input logic        evNoResp,
  input logic        evToggleAdv,
  input logic        fifoPtrReset,
  input logic        irqErr
);
  p_zero_bits_r1: assert property (@(posedge clk) disable iff (!rstN)
    rdData[15:12] == 4'h0 && !rdData[10] && !rdData[8]);
  p_tog_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[10] && !wrData[6] && !evToggleAdv) |=> $stable(rdData[9]));
  p_flush_noop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[8] && !rdData[0] && !rdData[1]) |=> !fifoPtrReset);
  p_tx_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    evTxDone |=> !rdData[1]);
  p_rx_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    evRxPkt |=> (rdData[0] && !rdData[5]));
  p_err_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    evNoResp |=> (irqErr && rdData[4]));
endmodule

bind ep0_host_ctrl_reg ep0_csr_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .evTxDone(evTxDone), .evRxPkt(evRxPkt), .evNoResp(evNoResp),
  .evToggleAdv(evToggleAdv), .fifoPtrReset(fifoPtrReset), .irqErr(irqErr)
);

// File: tb/ep0_host_ctrl_reg_tb.sv
module ep0_host_ctrl_reg_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic svcRxReady = 1'b0, irqTxEn = 1'b1;
  logic evTxDone = 1'b0, evRxPkt = 1'b0, evStall = 1'b0, evNoResp = 1'b0;
  logic evNakLimit = 1'b0, evToggleAdv = 1'b0;
  logic ctrlPingOff, ctrlToggle, ctrlStatusStage, ctrlInReq, ctrlSetup, ctrlTxReady;
  logic fifoPtrReset, irqTx, irqRx, irqErr;
  int nRun = 0, nFail = 0;

  always #4 clk = ~clk;

  ep0_host_ctrl_reg u_dut (.*);

  // vector: wr, data[16], ev[6]={adv,nak,noResp,stall,rxPkt,txDone}, svc, expRd[16], expPtr, expIrq{err,rx,tx}
  localparam int NV = 21;
  localparam logic [43:0] VEC [NV] = '{
    {1'b1,16'h0800,6'h00,1'b0,16'h0800,1'b0,3'b000}, // R11 ping bit
    {1'b1,16'h0E00,6'h00,1'b0,16'h0A00,1'b0,3'b000}, // R2 enabled load
    {1'b1,16'h0800,6'h00,1'b0,16'h0A00,1'b0,3'b000}, // R2 write ignored
    {1'b1,16'h0400,6'h00,1'b0,16'h0000,1'b0,3'b000}, // R2 load 0
    {1'b0,16'h0000,6'h20,1'b0,16'h0200,1'b0,3'b000}, // R4 advance
    {1'b1,16'h0400,6'h20,1'b0,16'h0000,1'b0,3'b000}, // R4 CPU beats advance
    {1'b1,16'h0062,6'h00,1'b0,16'h0262,1'b0,3'b000}, // R3 status stage
    {1'b0,16'h0000,6'h01,1'b0,16'h0260,1'b0,3'b001}, // R7 tx done
    {1'b0,16'h0000,6'h02,1'b0,16'h0241,1'b0,3'b010}, // R8 rx pkt
    {1'b1,16'h0000,6'h00,1'b0,16'h0201,1'b0,3'b000}, // R8 bit0 write ignored
    {1'b0,16'h0000,6'h00,1'b1,16'h0200,1'b0,3'b000}, // R8 service
    {1'b0,16'h0000,6'h1C,1'b0,16'h0294,1'b0,3'b100}, // R9 sticky sets
    {1'b1,16'h0000,6'h00,1'b0,16'h0200,1'b0,3'b000}, // R9 clear
    {1'b1,16'h0000,6'h04,1'b0,16'h0204,1'b0,3'b000}, // R10 stall beats write
    {1'b1,16'h0000,6'h02,1'b0,16'h0201,1'b0,3'b010}, // R10 rx with write
    {1'b1,16'h0108,6'h00,1'b0,16'h0208,1'b1,3'b000}, // R5 flush rx
    {1'b1,16'h0100,6'h00,1'b0,16'h0200,1'b0,3'b000}, // R6 flush no-op
    {1'b1,16'h0102,6'h00,1'b0,16'h0202,1'b0,3'b000}, // R6 flush + tx set
    {1'b1,16'h0100,6'h00,1'b0,16'h0200,1'b1,3'b000}, // R5 flush tx
    {1'b1,16'hF000,6'h00,1'b0,16'h0200,1'b0,3'b000}, // R1 reserved
    {1'b0,16'h0000,6'h02,1'b1,16'h0201,1'b0,3'b010}  // R10 rx beats service
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; wrData = '0; svcRxReady = 0;
    {evToggleAdv, evNakLimit, evNoResp, evStall, evRxPkt, evTxDone} = '0;
  endtask

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdData == 16'h0 && !fifoPtrReset && !irqTx && !irqRx && !irqErr,
          "R1 reset", rdData, 0);
    rstN = 1;
    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      wrEn = v[43]; wrData = v[42:27];
      {evToggleAdv, evNakLimit, evNoResp, evStall, evRxPkt, evTxDone} = v[26:21];
      svcRxReady = v[20];
      @(negedge clk);
      check(rdData == v[19:4], $sformatf("vec%0d rd", i), rdData, v[19:4]);
      check(fifoPtrReset == v[3], $sformatf("vec%0d ptr R5", i), fifoPtrReset, v[3]);
      check({irqErr, irqRx, irqTx} == v[2:0], $sformatf("vec%0d irq R7", i),
            {irqErr, irqRx, irqTx}, v[2:0]);
    end
    idle();
    // R11 mirrors
    wrEn = 1; wrData = 16'h086A;
    @(negedge clk); idle();
    check({ctrlPingOff, ctrlToggle, ctrlStatusStage, ctrlInReq, ctrlSetup, ctrlTxReady} == 6'b111111,
          "R11 mirror", {ctrlPingOff, ctrlToggle, ctrlStatusStage, ctrlInReq, ctrlSetup, ctrlTxReady}, 6'h3F);
    // R7 irq disabled
    irqTxEn = 0; evTxDone = 1;
    @(negedge clk); idle();
    check(!irqTx && !ctrlTxReady, "R7 irq disabled", {irqTx, ctrlTxReady}, 0);
    // R7 tx done with tx clear: no irq
    irqTxEn = 1; evTxDone = 1;
    @(negedge clk); idle();
    check(!irqTx, "R7 no irq when clear", irqTx, 0);
    // R7 pulse lasts one cycle
    wrEn = 1; wrData = 16'h0002;
    @(negedge clk); idle(); evTxDone = 1;
    @(negedge clk); idle();
    check(irqTx, "R7 irq pulse", irqTx, 1);
    @(negedge clk);
    check(!irqTx, "R7 irq single", irqTx, 0);
    // R1 mid-run reset
    wrEn = 1; wrData = 16'h0EFE;
    @(negedge clk); idle(); rstN = 0;
    @(negedge clk); rstN = 1;
    check(rdData == 16'h0, "R1 reset again", rdData, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule